// File: doc/BRIEF.md
# Wrapped Burst Address Generator

This block supplies the byte address sequence for a serial memory read burst. A burst opens at an arbitrary critical byte and, when wrapping is selected, keeps cycling through the naturally aligned window that contains that byte. The window is 8, 16, 32 or 64 bytes long and always fits inside one page, so a cache line can be filled with a single read command. When wrapping is off, the address simply counts upward through the whole 24-bit space.

A three-bit wrap configuration word is written before a burst. One bit chooses between wrapping and linear counting, and two bits choose the window length. A start pulse loads the critical address and latches the configuration for that burst. Each accepted data byte then advances the address by one step. A stop pulse, issued when chip select is released, closes the burst. The block also flags the byte that sits at the top of its window.

Top module: `wrap_burst_addr_gen`

## Requirements
- R1: After reset, `addr` is 0, `addr_valid` is 0 and `last_in_win` is 0. The configuration is linear with an 8-byte window.
- R2: One cycle after `start` is high, `addr` equals the `start_addr` sampled with it and `addr_valid` is 1. `start` takes precedence over `adv` and `stop` in the same cycle.
- R3: In wrap mode (`cfg_wdata[0]` = 0 when written), each advance keeps the address bits above the window and replaces the low bits with (low bits + 1) modulo the window length. The burst therefore returns to the window base, not to zero.
- R4: Length select `cfg_wdata[2:1]` = 00, 01, 10, 11 gives windows of 8, 16, 32 and 64 bytes.
- R5: In linear mode (`cfg_wdata[0]` = 1), each advance adds one to `addr` modulo 2^24, so 0xFFFFFF is followed by 0x000000.
- R6: `last_in_win` is 1 exactly when `addr_valid` is 1 and the low log2(length) bits of `addr` are all ones. In wrap mode the burst goes on past that byte.
- R7: `addr` does not change in a cycle with neither `start` nor an advance. `adv` has no effect while `addr_valid` is 0.
- R8: One cycle after `stop` (without `start`), `addr_valid` is 0 and `addr` holds its value.
- R9: The configuration is captured at `start`. A write during a burst has no effect until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| cfg_we | input | 1 | Write strobe for the wrap configuration word |
| cfg_wdata | input | 3 | Bit 0: 1 = linear, 0 = wrap; bits 2:1: window length select |
| start | input | 1 | Opens a burst at `start_addr` |
| start_addr | input | 24 | Critical byte address |
| adv | input | 1 | One data byte accepted; advance the address |
| stop | input | 1 | Chip select released; close the burst |
| addr | output | 24 | Current byte address |
| addr_valid | output | 1 | A burst is open |
| last_in_win | output | 1 | Current byte is the top byte of its window |

## Verification
Every result is registered. `addr` and `addr_valid` reflect a `start`, `adv` or `stop` one clock edge after it is sampled. `last_in_win` follows `addr` combinationally in that same cycle, and a configuration write first shows in the burst that the next `start` opens. The bench drives its inputs on the falling edge and compares outputs on the next falling edge, one full edge later. Before each new stimulus it predicts the address arithmetically from the window length and the mode. It also waits out the two-stage reset release before its first comparison.

// File: rtl/wbag_pkg.sv
package wbag_pkg;

  typedef enum logic {
    MODE_WRAP   = 1'b0,
    MODE_LINEAR = 1'b1
  } wbag_mode_e;

endpackage

// File: rtl/wbag_rst_sync.sv
module wbag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/wbag_cfg_reg.sv
module wbag_cfg_reg
  import wbag_pkg::*;
#(
  parameter int LEN_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [LEN_SEL_W:0]   wdata,
  output wbag_mode_e           mode,
  output logic [LEN_SEL_W-1:0] len_sel
);

  wbag_mode_e           mode_d;
  logic [LEN_SEL_W-1:0] len_sel_d;

  always_comb begin
    mode_d    = mode;
    len_sel_d = len_sel;
    if (we) begin
      mode_d    = wbag_mode_e'(wdata[0]);
      len_sel_d = wdata[LEN_SEL_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_LINEAR;
      len_sel <= '0;
    end else begin
      mode    <= mode_d;
      len_sel <= len_sel_d;
    end
  end

endmodule

// File: rtl/wbag_next_addr.sv
module wbag_next_addr
  import wbag_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_SEL_W    = 2,
  parameter int MIN_LEN_LOG2 = 3
) (
  input  logic [ADDR_W-1:0]    cur_addr,
  input  wbag_mode_e           mode,
  input  logic [LEN_SEL_W-1:0] len_sel,
  output logic [ADDR_W-1:0]    win_mask,
  output logic [ADDR_W-1:0]    nxt_addr,
  output logic                 win_top
);

  logic [ADDR_W-1:0] incr;
  int unsigned       span_log2;

  assign span_log2 = MIN_LEN_LOG2 + int'(len_sel);

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_mask
      assign win_mask[gi] = (gi < span_log2);
    end
  endgenerate

  assign incr = cur_addr + 1'b1;

  always_comb begin
    if (mode == MODE_WRAP) nxt_addr = (cur_addr & ~win_mask) | (incr & win_mask);
    else                   nxt_addr = incr;
  end

  assign win_top = ((cur_addr & win_mask) == win_mask);

endmodule

// File: rtl/wrap_burst_addr_gen.sv
module wrap_burst_addr_gen
  import wbag_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int LEN_SEL_W    = 2,
  parameter int MIN_LEN_LOG2 = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [LEN_SEL_W:0]   cfg_wdata,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic                 adv,
  input  logic                 stop,
  output logic [ADDR_W-1:0]    addr,
  output logic                 addr_valid,
  output logic                 last_in_win
);

  logic                 rst_n_sync;
  wbag_mode_e           cfg_mode;
  logic [LEN_SEL_W-1:0] cfg_len_sel;
  wbag_mode_e           b_mode,    b_mode_d;
  logic [LEN_SEL_W-1:0] b_len_sel, b_len_sel_d;
  logic [ADDR_W-1:0]    addr_d;
  logic                 valid_d;
  logic [ADDR_W-1:0]    b_mask;
  logic [ADDR_W-1:0]    step_addr;
  logic                 at_top;
  logic                 step_en;

  wbag_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  wbag_cfg_reg #(.LEN_SEL_W(LEN_SEL_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .mode   (cfg_mode),
    .len_sel(cfg_len_sel)
  );

  wbag_next_addr #(
    .ADDR_W      (ADDR_W),
    .LEN_SEL_W   (LEN_SEL_W),
    .MIN_LEN_LOG2(MIN_LEN_LOG2)
  ) u_next (
    .cur_addr(addr),
    .mode    (b_mode),
    .len_sel (b_len_sel),
    .win_mask(b_mask),
    .nxt_addr(step_addr),
    .win_top (at_top)
  );

  assign step_en = addr_valid && adv;

  always_comb begin
    addr_d      = addr;
    valid_d     = addr_valid;
    b_mode_d    = b_mode;
    b_len_sel_d = b_len_sel;
    if (start) begin
      addr_d      = start_addr;
      valid_d     = 1'b1;
      b_mode_d    = cfg_mode;
      b_len_sel_d = cfg_len_sel;
    end else begin
      if (step_en) addr_d  = step_addr;
      if (stop)    valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      addr       <= '0;
      addr_valid <= 1'b0;
      b_mode     <= MODE_LINEAR;
      b_len_sel  <= '0;
    end else begin
      addr       <= addr_d;
      addr_valid <= valid_d;
      b_mode     <= b_mode_d;
      b_len_sel  <= b_len_sel_d;
    end
  end

  assign last_in_win = addr_valid && at_top;

endmodule

// File: rtl/wbag_checker.sv
module wbag_checker
  import wbag_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic              adv,
  input logic              stop,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_valid,
  input logic              last_in_win,
  input wbag_mode_e        b_mode,
  input logic [ADDR_W-1:0] b_mask
);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_ni)
    start |=> (addr == $past(start_addr)) && addr_valid);

  a_r3_wrap_in_window: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr_valid && adv && !start && b_mode == MODE_WRAP) |=>
      ((addr & ~b_mask) == ($past(addr) & ~b_mask)) &&
      ((addr & b_mask) == (ADDR_W'($past(addr) + 1'b1) & b_mask)));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (addr_valid && adv && !start && b_mode == MODE_LINEAR) |=>
      addr == ADDR_W'($past(addr) + 1'b1));

  a_r6_top_returns_base: assert property (@(posedge clk) disable iff (!rst_ni)
    (last_in_win && adv && !start && b_mode == MODE_WRAP) |=> ((addr & b_mask) == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!start && !(addr_valid && adv)) |=> $stable(addr));

  a_r8_stop_closes: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop && !start) |=> !addr_valid);

endmodule

bind wrap_burst_addr_gen wbag_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_n_sync),
  .start      (start),
  .start_addr (start_addr),
  .adv        (adv),
  .stop       (stop),
  .addr       (addr),
  .addr_valid (addr_valid),
  .last_in_win(last_in_win),
  .b_mode     (b_mode),
  .b_mask     (b_mask)
);

// File: tb/wrap_burst_addr_gen_tb.sv
module wrap_burst_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_wdata;
  logic        start;
  logic [23:0] start_addr;
  logic        adv;
  logic        stop;
  logic [23:0] addr;
  logic        addr_valid;
  logic        last_in_win;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wrap_burst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .start_addr(start_addr), .adv(adv), .stop(stop),
    .addr(addr), .addr_valid(addr_valid), .last_in_win(last_in_win)
  );

  function automatic logic [23:0] mask_of(input int sel);
    return 24'((1 << (3 + sel)) - 1);
  endfunction

  function automatic logic [23:0] model_next(input logic [23:0] a, input logic lin, input int sel);
    logic [23:0] m;
    m = mask_of(sel);
    if (lin) return a + 24'd1;
    return (a & ~m) | ((a + 24'd1) & m);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [23:0] exp_a, input logic exp_v, input logic exp_l);
    n_cmp++;
    if (addr !== exp_a || addr_valid !== exp_v || last_in_win !== exp_l) begin
      n_bad++;
      $display("FAIL %s: addr=%h valid=%b last=%b expected addr=%h valid=%b last=%b",
               req, addr, addr_valid, last_in_win, exp_a, exp_v, exp_l);
    end
  endtask

  task automatic write_cfg(input logic lin, input int sel);
    cfg_we = 1'b1; cfg_wdata = {2'(sel), lin};
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic open_burst(input logic [23:0] a);
    start = 1'b1; start_addr = a;
    tick();
    start = 1'b0;
  endtask

  task automatic sweep(input logic lin, input int sel, input logic [23:0] sa);
    logic [23:0] e;
    logic [23:0] m;
    m = mask_of(sel);
    write_cfg(lin, sel);
    open_burst(sa);
    e = sa;
    check("R2 start load", e, 1'b1, (e & m) == m);
    adv = 1'b1;
    for (int k = 0; k < 2 * (8 << sel) + 2; k++) begin
      tick();
      e = model_next(e, lin, sel);
      if (lin) check("R5/R4/R6 linear step", e, 1'b1, (e & m) == m);
      else     check("R3/R4/R6 wrap step", e, 1'b1, (e & m) == m);
    end
    adv = 1'b0;
    stop = 1'b1;
    tick();
    stop = 1'b0;
    check("R8 stop", e, 1'b0, 1'b0);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; start = 1'b0;
    start_addr = '0; adv = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, then default linear 8-byte config observed
    check("R1 reset outputs", 24'h0, 1'b0, 1'b0);
    open_burst(24'h000005);
    check("R1 default start", 24'h000005, 1'b1, 1'b0);
    adv = 1'b1;
    tick(); check("R1 default step", 24'h000006, 1'b1, 1'b0);
    tick(); check("R1 default 8-byte top", 24'h000007, 1'b1, 1'b1);
    tick(); check("R1 default linear", 24'h000008, 1'b1, 1'b0);
    adv = 1'b0;
    stop = 1'b1; tick(); stop = 1'b0;

    // R3 R4 R5 R6: sweep modes, lengths and critical offsets
    for (int lin = 0; lin < 2; lin++)
      for (int sel = 0; sel < 4; sel++) begin
        int len = 8 << sel;
        sweep(lin[0], sel, 24'hABCD00);
        sweep(lin[0], sel, 24'hABCD00 + 24'(len - 1));
        sweep(lin[0], sel, 24'hABCD00 + 24'(len / 2 + 3));
        sweep(lin[0], sel, 24'hFFFFC0 + 24'(len - 2));
      end

    // R5: linear rollover across the top of the address space
    write_cfg(1'b1, 0);
    open_burst(24'hFFFFFE);
    adv = 1'b1;
    tick(); check("R5 top byte", 24'hFFFFFF, 1'b1, 1'b1);
    tick(); check("R5 rollover", 24'h000000, 1'b1, 1'b0);
    adv = 1'b0;

    // R7: no advance holds; R8 stop then adv ignored while idle
    tick(); check("R7 hold without adv", 24'h000000, 1'b1, 1'b0);
    stop = 1'b1; tick(); stop = 1'b0;
    check("R8 stop clears valid", 24'h000000, 1'b0, 1'b0);
    adv = 1'b1;
    tick(); tick(); check("R7 adv ignored when idle", 24'h000000, 1'b0, 1'b0);

    // R2: start wins over adv and stop in the same cycle
    start = 1'b1; stop = 1'b1; start_addr = 24'h345678;
    tick();
    start = 1'b0; stop = 1'b0; adv = 1'b0;
    check("R2 start precedence", 24'h345678, 1'b1, 1'b0);

    // R9: config write mid-burst does not affect the open burst
    write_cfg(1'b0, 0);
    open_burst(24'h100006);
    write_cfg(1'b1, 3);
    adv = 1'b1;
    tick(); check("R9 old config top", 24'h100007, 1'b1, 1'b1);
    tick(); check("R9 old config wraps", 24'h100000, 1'b1, 1'b0);
    adv = 1'b0;
    open_burst(24'h100006);
    adv = 1'b1;
    tick(); check("R9 new config step", 24'h100007, 1'b1, 1'b0);
    tick(); check("R9 new config linear", 24'h100008, 1'b1, 1'b0);
    adv = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule